// File: doc/BRIEF.md
# Fault-Aware Cache Index Remapper

This block is the lookup front end of a direct-mapped cache whose storage may contain blocks that failed manufacturing test. A per-block fault map is loaded by a test engine while a configuration enable is held high. During normal operation each access first decodes its index. If the indexed block is marked bad, the access is steered to a partner block, which is the same index with its most significant bit inverted. The usable cache then shrinks, and the processor keeps presenting ordinary addresses.

Two indexes can now share one physical block. To stop them aliasing, each stored tag carries one extra bit: the index MSB of the address that filled it. That bit is compared on every lookup, so a hit is still exact. When both blocks of a pair are bad, the access is a forced miss and a fill does nothing.

The block holds the fault map and the tag/valid store. It answers each lookup or fill with a registered response one cycle after the request: hit, forced-miss (bypass) flag and the physical block used.

Top module: `fault_remap_cache`

## Requirements
- R1: After reset every block is healthy and invalid, rsp_valid is low, and the first lookup of any address misses.
- R2: Each request (req_valid high at a rising edge) produces exactly one response, with rsp_valid high in the following cycle. No response appears without a request.
- R3: For a healthy index, a lookup after a fill of the same address hits on block index = address bits [OFF_W+IDX_W-1:OFF_W]. A lookup with a different tag (bits above the index) misses.
- R4: When the indexed block is marked faulty and its partner is healthy, the access uses the partner block (index XOR 2^(IDX_W-1)), and rsp_block reports that partner.
- R5: Addresses whose indexes differ only in the MSB and share a tag never hit on each other's fill, because the stored key includes the original index MSB.
- R6: When both blocks of a pair are faulty, the response has rsp_bypass=1 and rsp_hit=0, and a fill makes no block valid.
- R7: A fault-map write (fmap_we) is ignored unless cfg_en is high in the same cycle. fmap_faulty=1 marks a block bad and 0 marks it good.
- R8: Marking a block faulty invalidates it, and a faulty block never becomes valid. A block returned to health later stays invalid until it is filled again.
- R9: A fill request (req_fill=1) responds with rsp_hit=0 and installs the address in the selected block.
- R10: The offset bits [OFF_W-1:0] have no effect on lookup results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_fill | input | 1 | 1 = fill (install tag), 0 = lookup |
| req_addr | input | ADDR_W | Byte address of the request |
| cfg_en | input | 1 | Enables fault-map writes |
| fmap_we | input | 1 | Fault-map write strobe |
| fmap_idx | input | IDX_W | Block written in the fault map |
| fmap_faulty | input | 1 | New fault bit for that block |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_bypass | output | 1 | Both blocks of the pair faulty, forced miss |
| rsp_block | output | IDX_W | Physical block selected |

## Verification
The bench walks one address through four conditions: home block healthy, home faulty with partner healthy, both faulty, and home restored. This separates direct hits, redirected hits, forced misses and the invalidation that a fault marking leaves behind. Address pairs that share a tag and differ only in the index MSB, filled alternately into one shared block, show whether the extra key bit prevents aliasing. Gated fault writes with cfg_en low, lookups that vary only the offset, and fills and lookups swept over many indexes with varied tags cover the enable gating, offset independence and plain direct-mapped behaviour.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_FILL   = 1'b1
  } frc_op_e;

  // Partner of a block: same index with the top index bit inverted.
  function automatic int unsigned partner_of(int unsigned idx, int unsigned idx_w);
    return idx ^ (32'd1 << (idx_w - 1));
  endfunction

endpackage

// File: rtl/frc_fault_map.sv
module frc_fault_map #(
  parameter int NBLK  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wval,
  output logic [NBLK-1:0]  fault_vec,
  output logic [NBLK-1:0]  mark_vec
);

  logic accept;
  assign accept = cfg_en && we;

  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    logic sel;
    assign sel         = accept && (widx == IDX_W'(g));
    assign mark_vec[g] = sel && wval;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fault_vec[g] <= 1'b0;
      else if (sel) fault_vec[g] <= wval;
    end
  end

endmodule

// File: rtl/frc_steer.sv
module frc_steer #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  parameter int NBLK   = 16,
  parameter int TAG_W  = 10,
  parameter int KEY_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBLK-1:0]   fault_vec,
  output logic [IDX_W-1:0]  home_idx,
  output logic [IDX_W-1:0]  phys_idx,
  output logic              bypass,
  output logic [KEY_W-1:0]  key
);
  import frc_pkg::*;

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [KEY_W-1:0] key_of(logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] i;
    i = idx_of(a);
    return {i[IDX_W-1], tag_of(a)};
  endfunction

  logic [IDX_W-1:0] pair_idx;
  logic             home_bad;
  logic             pair_bad;

  assign home_idx = idx_of(addr);
  assign pair_idx = IDX_W'(partner_of(int'(home_idx), IDX_W));
  assign home_bad = fault_vec[home_idx];
  assign pair_bad = fault_vec[pair_idx];
  assign phys_idx = home_bad ? pair_idx : home_idx;
  assign bypass   = home_bad && pair_bad;
  assign key      = key_of(addr);

endmodule

// File: rtl/frc_tag_store.sv
module frc_tag_store #(
  parameter int NBLK  = 16,
  parameter int IDX_W = 4,
  parameter int KEY_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [NBLK-1:0]  clr_vec,
  output logic [NBLK-1:0]  valid_vec
);

  logic [KEY_W-1:0] key_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        key_q[g]     <= '0;
      end else begin
        if (clr_vec[g])  valid_vec[g] <= 1'b0;
        else if (hit_wr) valid_vec[g] <= 1'b1;
        if (hit_wr)      key_q[g]     <= wr_key;
      end
    end
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_key   = key_q[rd_idx];

endmodule

// File: rtl/fault_remap_cache.sv
module fault_remap_cache #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_fill,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_en,
  input  logic              fmap_we,
  input  logic [IDX_W-1:0]  fmap_idx,
  input  logic              fmap_faulty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_bypass,
  output logic [IDX_W-1:0]  rsp_block
);
  import frc_pkg::*;

  localparam int NBLK  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int KEY_W = TAG_W + 1;

  // Named internal events for the checker.
  logic [NBLK-1:0]  fault_vec;
  logic [NBLK-1:0]  mark_vec;
  logic [NBLK-1:0]  valid_vec;
  logic [IDX_W-1:0] home_idx;
  logic [IDX_W-1:0] phys_idx;
  logic             bypass;
  logic [KEY_W-1:0] key;
  logic             rd_valid;
  logic [KEY_W-1:0] rd_key;
  logic             fill_we;
  logic             lookup_hit;
  frc_op_e          op;

  assign op = req_fill ? OP_FILL : OP_LOOKUP;

  frc_fault_map #(.NBLK(NBLK), .IDX_W(IDX_W)) u_fmap (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .we(fmap_we),
    .widx(fmap_idx), .wval(fmap_faulty),
    .fault_vec(fault_vec), .mark_vec(mark_vec)
  );

  frc_steer #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .NBLK(NBLK), .TAG_W(TAG_W), .KEY_W(KEY_W)
  ) u_steer (
    .addr(req_addr), .fault_vec(fault_vec),
    .home_idx(home_idx), .phys_idx(phys_idx), .bypass(bypass), .key(key)
  );

  assign fill_we    = req_valid && (op == OP_FILL) && !bypass;
  assign lookup_hit = (op == OP_LOOKUP) && !bypass && rd_valid && (rd_key == key);

  frc_tag_store #(.NBLK(NBLK), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(phys_idx), .rd_valid(rd_valid), .rd_key(rd_key),
    .wr_en(fill_we), .wr_idx(phys_idx), .wr_key(key),
    .clr_vec(mark_vec), .valid_vec(valid_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_block  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= lookup_hit;
        rsp_bypass <= bypass;
        rsp_block  <= phys_idx;
      end
    end
  end

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_fill,
  input logic            cfg_en,
  input logic            fmap_we,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_bypass,
  input logic [NBLK-1:0] fault_vec,
  input logic [NBLK-1:0] valid_vec
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_bypass_never_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bypass) |-> !rsp_hit);

  assert_fill_reports_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fill) |=> !rsp_hit);

  assert_faulty_block_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vec & valid_vec) == '0);

  assert_fmap_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && fmap_we) |=> $stable(fault_vec));

endmodule

bind fault_remap_cache frc_checker #(.NBLK(NBLK)) u_frc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
  .cfg_en(cfg_en), .fmap_we(fmap_we), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_bypass(rsp_bypass),
  .fault_vec(fault_vec), .valid_vec(valid_vec)
);

// File: tb/fault_remap_cache_bench.sv
module fault_remap_cache_bench;

  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 2;
  localparam int NBLK   = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_fill = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              cfg_en = 1'b0;
  logic              fmap_we = 1'b0;
  logic [IDX_W-1:0]  fmap_idx = '0;
  logic              fmap_faulty = 1'b0;
  logic              rsp_valid;
  logic              rsp_hit;
  logic              rsp_bypass;
  logic [IDX_W-1:0]  rsp_block;

  always #2.5 clk = ~clk;

  fault_remap_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fault_remap_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
    .req_addr(req_addr), .cfg_en(cfg_en), .fmap_we(fmap_we),
    .fmap_idx(fmap_idx), .fmap_faulty(fmap_faulty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bypass(rsp_bypass),
    .rsp_block(rsp_block)
  );

  // Reference model state.
  bit        m_fault [NBLK];
  bit        m_valid [NBLK];
  bit [31:0] m_key   [NBLK];

  // Scoreboard: {hit, bypass, block}.
  logic [IDX_W+1:0] exp_q [$];
  string            tag_q [$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  function automatic logic [ADDR_W-1:0] mk_addr(int tag, int idx, int off);
    return ADDR_W'((tag << (IDX_W + OFF_W)) | (idx << OFF_W) | off);
  endfunction

  task automatic request(bit fill, int tag, int idx, int off, string rq);
    int  top_bit = idx >> (IDX_W - 1);
    int  pair = idx ^ (NBLK / 2);
    int  blk;
    bit  byp;
    bit  hit;
    int  k = (top_bit << TAG_W) | tag;
    @(negedge clk);
    blk = m_fault[idx] ? pair : idx;
    byp = m_fault[idx] && m_fault[pair];
    hit = !fill && !byp && m_valid[blk] && (m_key[blk] == 32'(k));
    if (fill && !byp) begin
      m_valid[blk] = 1'b1;
      m_key[blk]   = 32'(k);
    end
    exp_q.push_back({hit, byp, IDX_W'(blk)});
    tag_q.push_back(rq);
    req_valid = 1'b1;
    req_fill  = fill;
    req_addr  = mk_addr(tag, idx, off);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    fmap_we   = 1'b0;
  endtask

  task automatic fault_write(bit en, int idx, bit val);
    @(negedge clk);
    req_valid   = 1'b0;
    cfg_en      = en;
    fmap_we     = 1'b1;
    fmap_idx    = IDX_W'(idx);
    fmap_faulty = val;
    if (en) begin
      m_fault[idx] = val;
      if (val) m_valid[idx] = 1'b0;
    end
    @(negedge clk);
    fmap_we = 1'b0;
    cfg_en  = 1'b0;
  endtask

  // Monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [IDX_W+1:0] act;
      act = {rsp_hit, rsp_bypass, rsp_block};
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R2: unexpected response act=%b exp=none", act);
      end else begin
        logic [IDX_W+1:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        if (act !== e) begin
          mismatched++;
          $display("FAIL %s: {hit,bypass,block} act=%b exp=%b", r, act, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NBLK; i++) begin
      m_fault[i] = 1'b0;
      m_valid[i] = 1'b0;
      m_key[i]   = 0;
    end
    repeat (3) @(negedge clk);
    compared++;
    if (rsp_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: rsp_valid during reset act=%b exp=0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (rsp_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: rsp_valid after reset act=%b exp=0", rsp_valid);
    end

    // R1: empty cache misses everywhere probed.
    request(0, 5, 3, 0, "R1");
    request(0, 9, 12, 1, "R1");
    // R3 / R9 / R10: healthy fill then lookups.
    request(1, 5, 3, 0, "R9");
    request(0, 5, 3, 0, "R3");
    request(0, 5, 3, 2, "R10");
    request(0, 5, 3, 3, "R10");
    request(0, 6, 3, 0, "R3");
    idle();
    // R7: gated write ignored.
    fault_write(0, 3, 1);
    request(0, 5, 3, 0, "R7");
    idle();
    // R8 / R4: mark home bad, redirect to partner 11.
    fault_write(1, 3, 1);
    request(0, 5, 3, 0, "R8");
    request(1, 5, 3, 1, "R4");
    request(0, 5, 3, 0, "R4");
    // R5: alias with idx 11 same tag.
    request(0, 5, 11, 0, "R5");
    request(1, 5, 11, 0, "R5");
    request(0, 5, 3, 0, "R5");
    request(0, 5, 11, 2, "R5");
    idle();
    // R6: both bad.
    fault_write(1, 11, 1);
    request(0, 5, 3, 0, "R6");
    request(1, 5, 3, 0, "R6");
    request(0, 5, 3, 0, "R6");
    request(0, 5, 11, 0, "R6");
    idle();
    // R8: restored block stays invalid until refilled.
    fault_write(1, 3, 0);
    request(0, 5, 3, 0, "R8");
    request(1, 5, 3, 0, "R9");
    request(0, 5, 3, 0, "R8");
    request(0, 5, 11, 0, "R4");
    idle();
    fault_write(1, 11, 0);
    // R3: sweep over indexes with varied tags.
    for (int i = 0; i < NBLK; i++) request(1, (i * 37 + 11) % 1024, i, i % 4, "R3");
    for (int i = 0; i < NBLK; i++) request(0, (i * 37 + 11) % 1024, i, 0, "R3");
    for (int i = 0; i < NBLK; i += 3) request(0, (i * 37 + 12) % 1024, i, 0, "R3");
    idle();
    repeat (3) @(negedge clk);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R2: responses missing act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end

endmodule